// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative address translation buffer. Every entry holds one tag that covers a pair of adjacent virtual pages, an even page and an odd page. Each half of the pair has its own physical frame base and its own valid, dirty, read-inhibit and execute-inhibit bits. A per-entry page mask widens the pair from the minimum 4 KB page size to larger sizes. An entry can also carry a hardware-invalidate flag, which removes it from matching without clearing its other fields.

Software, or a walker outside this block, loads an entry through a write port at a chosen index. A lookup presents a virtual address, the current address-space identifier and the access kind. One cycle later the block returns a registered result with a valid strobe. The result holds a result code, the physical address and a write-permission flag. The code tells the caller whether the access may proceed or which fault it raised.

Top module: `paired_tlb`

## Requirements
- R1: After reset every entry carries the hardware-invalidate flag, so every lookup returns code 1 (no match), and `rs_valid` is low until the first lookup.
- R2: A lookup presented with `lk_req` high at a rising edge produces `rs_valid` high for exactly the following cycle, together with its result; `rs_valid` is low after any edge where `lk_req` was low.
- R3: An entry matches when (its global bit is set or its stored identifier equals `lk_asid`), its tag equals the address outside the compare mask, and its hardware-invalidate flag is clear.
- R4: The compare mask is the entry's page mask ORed with 0x1FFF (two 4 KB pages), so a 16 KB pair uses page mask 0x6000 and address bits from bit 15 upward take part in the tag compare.
- R5: The half is chosen by the highest bit of the compare mask (bit 12 for 4 KB pages, bit 14 for 16 KB pages): set selects the odd half. The physical address is that half's frame base ORed with the address bits of the compare mask shifted right by one.
- R6: If the chosen half's valid bit is clear the code is 2 (invalid), whatever the access kind.
- R7: Access kind is 0 fetch, 1 load, 2 store, and 3 is treated as a load. A fetch to a half with execute-inhibit set gives code 4. A load to a half with read-inhibit set gives code 5.
- R8: A store to a half whose dirty bit is clear gives code 3 (modified). A store to a dirty half gives code 0 (hit).
- R9: On code 0, `rs_writable` equals the chosen half's dirty bit. On any other code, `rs_pa` and `rs_writable` are zero.
- R10: When no entry matches, the code is 1 (no match).
- R11: When several entries match, the one at the lowest index supplies the result.
- R12: An entry written at a rising edge with `wr_en` high replaces every field at `wr_idx` and takes part in lookups presented from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load an entry this cycle |
| wr_idx | input | 4 | Index of the entry to load |
| wr_vpn | input | 32 | Virtual tag of the pair |
| wr_pmask | input | 32 | Page mask widening the pair |
| wr_asid | input | 8 | Address-space identifier of the entry |
| wr_global | input | 1 | Entry matches any identifier |
| wr_hinv | input | 1 | Hardware-invalidate flag |
| wr_pfn_even | input | 32 | Physical frame base of the even half |
| wr_pfn_odd | input | 32 | Physical frame base of the odd half |
| wr_valid | input | 2 | Valid bits, [1] odd, [0] even |
| wr_dirty | input | 2 | Dirty bits, [1] odd, [0] even |
| wr_rinh | input | 2 | Read-inhibit bits, [1] odd, [0] even |
| wr_xinh | input | 2 | Execute-inhibit bits, [1] odd, [0] even |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| rs_valid | output | 1 | Result strobe |
| rs_code | output | 3 | Result code 0..5 |
| rs_pa | output | 32 | Translated physical address |
| rs_writable | output | 1 | Write permission for the page |

## Verification
The hardest situation to reach is two entries that match the same address at once, because a correct loader never creates such an overlap. The stimulus loads two entries with the same tag and identifier on purpose and checks that the lower index wins. It then sets the hardware-invalidate flag on the winner and checks that the other entry takes over. The fault-ordering cases are set up the same way. An entry with an invalid odd half is probed with a store, so the invalid check is shown to take precedence over the dirty check.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

  localparam int VA_W       = 32;
  localparam int PA_W       = 32;
  localparam int ASID_W     = 8;
  localparam int PAGE_SHIFT = 12;

  // bits covered by the smallest even/odd pair
  localparam logic [VA_W-1:0] PAIR_SPAN = VA_W'((64'd1 << (PAGE_SHIFT + 1)) - 64'd1);

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    RES_HIT      = 3'd0,
    RES_MISS     = 3'd1,
    RES_INVALID  = 3'd2,
    RES_MODIFIED = 3'd3,
    RES_XINH     = 3'd4,
    RES_RINH     = 3'd5
  } res_e;

  typedef struct packed {
    logic [VA_W-1:0]   vpn;
    logic [VA_W-1:0]   pmask;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic              hinv;
    logic [PA_W-1:0]   pfn_odd;
    logic [PA_W-1:0]   pfn_even;
    logic [1:0]        valid;
    logic [1:0]        dirty;
    logic [1:0]        rinh;
    logic [1:0]        xinh;
  } tlb_ent_t;

  function automatic logic [VA_W-1:0] cmp_mask(input logic [VA_W-1:0] pm);
    return pm | PAIR_SPAN;
  endfunction

  function automatic logic [VA_W-1:0] half_bit(input logic [VA_W-1:0] m);
    return m & ~(m >> 1);
  endfunction

  function automatic logic tag_eq(input logic [VA_W-1:0] vpn,
                                  input logic [VA_W-1:0] va,
                                  input logic [VA_W-1:0] m);
    return (vpn & ~m) == (va & ~m);
  endfunction

  function automatic logic [PA_W-1:0] phys(input logic [PA_W-1:0] pfn,
                                           input logic [VA_W-1:0] va,
                                           input logic [VA_W-1:0] m);
    return pfn | PA_W'(va & (m >> 1));
  endfunction

  function automatic tlb_ent_t reset_entry();
    tlb_ent_t e;
    e      = '0;
    e.hinv = 1'b1;
    return e;
  endfunction

endpackage

// File: rtl/ptlb_store.sv
module ptlb_store
  import ptlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tlb_ent_t         wr_ent,
  output tlb_ent_t         ent_q [NUM_ENTRIES]
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) ent_q[i] <= reset_entry();
    end else if (wr_en) begin
      ent_q[wr_idx] <= wr_ent;
    end
  end

  // R12
  ent_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent_q[$past(wr_idx)] == $past(wr_ent));

endmodule

// File: rtl/ptlb_match.sv
module ptlb_match
  import ptlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  tlb_ent_t          ent_q [NUM_ENTRIES],
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] asid,
  output logic [NUM_ENTRIES-1:0] hit_vec,
  output logic [NUM_ENTRIES-1:0] odd_vec
);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_row
    logic [VA_W-1:0] m;
    logic            id_ok;
    assign m          = cmp_mask(ent_q[g].pmask);
    assign id_ok      = ent_q[g].glob || (ent_q[g].asid == asid);
    assign hit_vec[g] = id_ok && tag_eq(ent_q[g].vpn, va, m) && !ent_q[g].hinv;
    assign odd_vec[g] = |(va & half_bit(m));
  end

endmodule

// File: rtl/ptlb_resolve.sv
module ptlb_resolve
  import ptlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  tlb_ent_t               ent_q [NUM_ENTRIES],
  input  logic [NUM_ENTRIES-1:0] hit_vec,
  input  logic [NUM_ENTRIES-1:0] odd_vec,
  input  logic [VA_W-1:0]        va,
  input  acc_e                   kind,
  output res_e                   code,
  output logic [PA_W-1:0]        pa,
  output logic                   writable
);

  logic [IDX_W-1:0] sel;
  logic             any_hit;
  logic             half;
  logic             half_valid;
  tlb_ent_t         e;
  logic [VA_W-1:0]  m;

  // lowest matching index wins
  always_comb begin
    sel = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel = IDX_W'(i);
    end
  end

  assign any_hit    = |hit_vec;
  assign e          = ent_q[sel];
  assign half       = odd_vec[sel];
  assign half_valid = e.valid[half];
  assign m          = cmp_mask(e.pmask);

  always_comb begin
    code     = RES_MISS;
    pa       = '0;
    writable = 1'b0;
    if (any_hit) begin
      if (!half_valid)                            code = RES_INVALID;
      else if (kind == ACC_FETCH && e.xinh[half]) code = RES_XINH;
      else if ((kind == ACC_LOAD || kind == ACC_RSVD) && e.rinh[half])
                                                  code = RES_RINH;
      else if (kind == ACC_STORE && !e.dirty[half]) code = RES_MODIFIED;
      else begin
        code     = RES_HIT;
        pa       = phys(half ? e.pfn_odd : e.pfn_even, va, m);
        writable = e.dirty[half];
      end
    end
  end

  // R10
  nomatch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> code == RES_MISS);

  // R6
  invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_hit && !half_valid) |-> code == RES_INVALID);

endmodule

// File: rtl/paired_tlb.sv
module paired_tlb
  import ptlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VA_W-1:0]   wr_vpn,
  input  logic [VA_W-1:0]   wr_pmask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic              wr_hinv,
  input  logic [PA_W-1:0]   wr_pfn_even,
  input  logic [PA_W-1:0]   wr_pfn_odd,
  input  logic [1:0]        wr_valid,
  input  logic [1:0]        wr_dirty,
  input  logic [1:0]        wr_rinh,
  input  logic [1:0]        wr_xinh,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [1:0]        lk_kind,
  output logic              rs_valid,
  output logic [2:0]        rs_code,
  output logic [PA_W-1:0]   rs_pa,
  output logic              rs_writable
);

  tlb_ent_t               wr_ent;
  tlb_ent_t               ent_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hit_vec;
  logic [NUM_ENTRIES-1:0] odd_vec;
  res_e                   nx_code;
  logic [PA_W-1:0]        nx_pa;
  logic                   nx_writable;

  always_comb begin
    wr_ent          = '0;
    wr_ent.vpn      = wr_vpn;
    wr_ent.pmask    = wr_pmask;
    wr_ent.asid     = wr_asid;
    wr_ent.glob     = wr_global;
    wr_ent.hinv     = wr_hinv;
    wr_ent.pfn_even = wr_pfn_even;
    wr_ent.pfn_odd  = wr_pfn_odd;
    wr_ent.valid    = wr_valid;
    wr_ent.dirty    = wr_dirty;
    wr_ent.rinh     = wr_rinh;
    wr_ent.xinh     = wr_xinh;
  end

  ptlb_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_ent (wr_ent),
    .ent_q  (ent_q)
  );

  ptlb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
    .ent_q   (ent_q),
    .va      (lk_va),
    .asid    (lk_asid),
    .hit_vec (hit_vec),
    .odd_vec (odd_vec)
  );

  ptlb_resolve #(.NUM_ENTRIES(NUM_ENTRIES)) u_resolve (
    .clk      (clk),
    .rst_n    (rst_n),
    .ent_q    (ent_q),
    .hit_vec  (hit_vec),
    .odd_vec  (odd_vec),
    .va       (lk_va),
    .kind     (acc_e'(lk_kind)),
    .code     (nx_code),
    .pa       (nx_pa),
    .writable (nx_writable)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid    <= 1'b0;
      rs_code     <= RES_MISS;
      rs_pa       <= '0;
      rs_writable <= 1'b0;
    end else begin
      rs_valid <= lk_req;
      if (lk_req) begin
        rs_code     <= nx_code;
        rs_pa       <= nx_pa;
        rs_writable <= nx_writable;
      end
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rs_valid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rs_valid);

  // R9
  write_perm_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_writable) |-> rs_code == RES_HIT);

  // R9
  pa_zero_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_code != RES_HIT) |-> rs_pa == '0);

endmodule

// File: tb/sim_paired_tlb.sv
module sim_paired_tlb;

  localparam int CLK_PERIOD = 10;
  localparam int NV         = 16;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [31:0] va;
    logic [7:0]  asid;
    logic [1:0]  kind;
    logic [2:0]  code;
    logic [31:0] pa;
    logic        wr;
    logic [7:0]  req;
  } vec_t;

  // kinds: 0 fetch, 1 load, 2 store; codes: 0 hit 1 miss 2 inv 3 mod 4 xi 5 ri
  localparam vec_t VECS [NV] = '{
    '{32'h0040_0123, 8'd5, 2'd1, 3'd0, 32'h1000_0123, 1'b1, 8'd5},  // R5 even
    '{32'h0040_1456, 8'd5, 2'd1, 3'd0, 32'h2000_0456, 1'b0, 8'd9},  // R9 odd clean
    '{32'h0040_1456, 8'd5, 2'd2, 3'd3, 32'h0,         1'b0, 8'd8},  // R8 modified
    '{32'h0040_0010, 8'd5, 2'd2, 3'd0, 32'h1000_0010, 1'b1, 8'd8},  // R8 dirty store
    '{32'h0040_0010, 8'd6, 2'd1, 3'd1, 32'h0,         1'b0, 8'd3},  // R3 asid
    '{32'h0080_2abc, 8'd7, 2'd0, 3'd4, 32'h0,         1'b0, 8'd7},  // R7 xi
    '{32'h0080_2abc, 8'd7, 2'd1, 3'd0, 32'h0300_2abc, 1'b1, 8'd4},  // R4 16K global
    '{32'h0080_5abc, 8'd7, 2'd1, 3'd2, 32'h0,         1'b0, 8'd6},  // R6 invalid
    '{32'h0100_0000, 8'd5, 2'd1, 3'd1, 32'h0,         1'b0, 8'd10}, // R10 hinv
    '{32'h0200_1000, 8'd5, 2'd1, 3'd5, 32'h0,         1'b0, 8'd7},  // R7 ri
    '{32'h0200_1000, 8'd5, 2'd0, 3'd0, 32'h0500_0000, 1'b1, 8'd7},  // R7 fetch ok
    '{32'h0200_0800, 8'd5, 2'd1, 3'd0, 32'h0400_0800, 1'b1, 8'd5},  // R5
    '{32'h0300_0044, 8'd5, 2'd1, 3'd0, 32'h0600_0044, 1'b1, 8'd11}, // R11
    '{32'h0080_8000, 8'd7, 2'd1, 3'd1, 32'h0,         1'b0, 8'd4},  // R4 beyond pair
    '{32'h0040_1456, 8'd5, 2'd0, 3'd0, 32'h2000_0456, 1'b0, 8'd5},  // R5 odd fetch
    '{32'h0080_5abc, 8'd7, 2'd2, 3'd2, 32'h0,         1'b0, 8'd6}   // R6 before dirty
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [31:0] wr_vpn, wr_pmask, wr_pfn_even, wr_pfn_odd;
  logic [7:0]  wr_asid;
  logic        wr_global, wr_hinv;
  logic [1:0]  wr_valid, wr_dirty, wr_rinh, wr_xinh;
  logic        lk_req;
  logic [31:0] lk_va;
  logic [7:0]  lk_asid;
  logic [1:0]  lk_kind;
  logic        rs_valid;
  logic [2:0]  rs_code;
  logic [31:0] rs_pa;
  logic        rs_writable;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paired_tlb u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_pmask(wr_pmask), .wr_asid(wr_asid),
    .wr_global(wr_global), .wr_hinv(wr_hinv),
    .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
    .wr_valid(wr_valid), .wr_dirty(wr_dirty), .wr_rinh(wr_rinh), .wr_xinh(wr_xinh),
    .lk_req(lk_req), .lk_va(lk_va), .lk_asid(lk_asid), .lk_kind(lk_kind),
    .rs_valid(rs_valid), .rs_code(rs_code), .rs_pa(rs_pa), .rs_writable(rs_writable)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic load_entry(input int idx, input logic [31:0] vpn, input logic [31:0] pm,
                            input logic [7:0] asid, input logic g, input logic hinv,
                            input logic [31:0] pe, input logic [31:0] po,
                            input logic [1:0] v, input logic [1:0] d,
                            input logic [1:0] ri, input logic [1:0] xi);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn = vpn; wr_pmask = pm; wr_asid = asid;
    wr_global = g; wr_hinv = hinv; wr_pfn_even = pe; wr_pfn_odd = po;
    wr_valid = v; wr_dirty = d; wr_rinh = ri; wr_xinh = xi;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // request at one negedge, registered at the posedge, sampled at the next negedge
  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] kind);
    @(negedge clk);
    lk_req = 1'b1; lk_va = va; lk_asid = asid; lk_kind = kind;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_vpn = '0; wr_pmask = '0; wr_asid = '0;
    wr_global = 1'b0; wr_hinv = 1'b0; wr_pfn_even = '0; wr_pfn_odd = '0;
    wr_valid = '0; wr_dirty = '0; wr_rinh = '0; wr_xinh = '0;
    lk_req = 1'b0; lk_va = '0; lk_asid = '0; lk_kind = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rs_valid after reset", 32'(rs_valid), 32'd0);

    // R1: reset entries carry the invalidate flag, even address 0 / asid 0 misses
    lookup(32'h0000_0000, 8'd0, 2'd1);
    check("R1 code after reset", 32'(rs_code), 32'd1);
    check("R2 rs_valid strobe", 32'(rs_valid), 32'd1);
    @(negedge clk);
    check("R2 rs_valid drops", 32'(rs_valid), 32'd0);

    load_entry(0, 32'h0040_0000, 32'h0, 8'd5, 1'b0, 1'b0, 32'h1000_0000, 32'h2000_0000,
               2'b11, 2'b01, 2'b00, 2'b00);
    load_entry(1, 32'h0080_0000, 32'h0000_6000, 8'd9, 1'b1, 1'b0, 32'h0300_0000, 32'h0310_0000,
               2'b01, 2'b11, 2'b00, 2'b01);
    load_entry(2, 32'h0100_0000, 32'h0, 8'd5, 1'b0, 1'b1, 32'h0800_0000, 32'h0900_0000,
               2'b11, 2'b11, 2'b00, 2'b00);
    load_entry(3, 32'h0200_0000, 32'h0, 8'd5, 1'b0, 1'b0, 32'h0400_0000, 32'h0500_0000,
               2'b11, 2'b11, 2'b10, 2'b00);
    load_entry(5, 32'h0300_0000, 32'h0, 8'd5, 1'b0, 1'b0, 32'h0700_0000, 32'h0710_0000,
               2'b11, 2'b11, 2'b00, 2'b00);
    load_entry(4, 32'h0300_0000, 32'h0, 8'd5, 1'b0, 1'b0, 32'h0600_0000, 32'h0610_0000,
               2'b11, 2'b11, 2'b00, 2'b00);

    for (int i = 0; i < NV; i++) begin
      string tag;
      lookup(VECS[i].va, VECS[i].asid, VECS[i].kind);
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      check({tag, " code"},     32'(rs_code),     32'(VECS[i].code));
      check({tag, " pa"},       rs_pa,            VECS[i].pa);
      check({tag, " writable"}, 32'(rs_writable), 32'(VECS[i].wr));
    end

    // R11 / R12: invalidate the winning entry, the higher index takes over
    load_entry(4, 32'h0300_0000, 32'h0, 8'd5, 1'b0, 1'b1, 32'h0600_0000, 32'h0610_0000,
               2'b11, 2'b11, 2'b00, 2'b00);
    lookup(32'h0300_0044, 8'd5, 2'd1);
    check("R12 rewrite code", 32'(rs_code), 32'd0);
    check("R11 next index pa", rs_pa, 32'h0700_0044);

    // R7: kind 3 behaves like a load against read-inhibit
    lookup(32'h0200_1000, 8'd5, 2'd3);
    check("R7 kind3 read-inhibit", 32'(rs_code), 32'd5);

    // R2: result fields hold while no request and strobe stays low
    @(negedge clk);
    check("R2 idle strobe", 32'(rs_valid), 32'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule